// File: doc/BRIEF.md
# Dual-Section Bus Transceiver with Parity Generate and Check

This block is a combinational pair of noninverting byte-wide bus transceivers. Each section joins an A-side bus to a B-side bus and has its own controls. A direction input picks the driving side. A high-impedance request releases both sides. A sense input selects odd or even parity. Each section also has a parity pin. When the section transmits from A to B, it computes a parity bit from the A byte and drives it onto that pin. When it receives from B to A, the same pin becomes an input. The block then checks the B byte plus that bit against the selected sense and pulls an active-low error flag when they disagree.

Each bidirectional pin appears as three signals: the value seen on the pin, the value the block would drive, and a drive enable. The enclosing pad ring or bus model combines them. No more than one side of a section drives at a time. The block has no clock and no state, so every output follows its inputs in the same evaluation.

The section count and the byte width are parameters. A further parameter selects how the parity reduction is built: as one flat XOR reduction or as a ripple chain.

Top module: `parity_xcvr`

## Requirements
- R1: With the section's high-impedance request low and its direction input high (transmit), the B-side drive enable is 1, the A-side drive enable is 0 and the B output equals the A input bit for bit.
- R2: With the high-impedance request low and the direction input low (receive), the A-side drive enable is 1, the B-side drive enable is 0 and the A output equals the B input bit for bit.
- R3: With the section's high-impedance request high, the A, B and parity drive enables are all 0 and the error flag is 1, for any value of the other inputs.
- R4: In transmit, the parity drive enable is 1. The parity output is 1 exactly when the number of ones on the A input, plus the parity output itself, has the selected sense (sense input 1 = odd total, 0 = even total).
- R5: In receive, the parity drive enable is 0. The error flag is 0 exactly when the number of ones on the B input plus the parity input does not match the selected sense (1 = odd, 0 = even); otherwise it is 1.
- R6: In transmit, the error flag is 1 whatever the B input and the parity input hold.
- R7: An output whose drive enable is 0 carries all zeros, so a released data bus or parity pin shows 0 on its output value.
- R8: Sections are independent. The outputs of one section depend only on that section's slice of the inputs (section k uses bits k*8 to k*8+7 of the data vectors and bit k of the control vectors).
- R9: Within a section, the A-side and B-side drive enables are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_tx | input | NSECT | Per section: 1 = A drives B (transmit), 0 = B drives A (receive) |
| hiz_req | input | NSECT | Per section: 1 = release both data sides and the parity pin |
| odd_sel | input | NSECT | Per section parity sense: 1 = odd, 0 = even |
| a_in | input | NSECT*DW | Value seen on the A-side pins |
| a_out | output | NSECT*DW | Value the block drives onto the A-side pins |
| a_drv | output | NSECT | A-side drive enable per section |
| b_in | input | NSECT*DW | Value seen on the B-side pins |
| b_out | output | NSECT*DW | Value the block drives onto the B-side pins |
| b_drv | output | NSECT | B-side drive enable per section |
| par_in | input | NSECT | Value seen on each parity pin |
| par_out | output | NSECT | Generated parity bit per section |
| par_drv | output | NSECT | Parity pin drive enable per section |
| err_n | output | NSECT | Active-low parity error flag per section |

## Verification
The bench sweeps every byte value on section 0 under every combination of direction, release, sense and parity input. Section 1 gets a different pattern at the same time, so wrong slice indexing or crosstalk between sections shows up as a mismatch on the other section. The parity checks cover both senses across all 256 bytes. A parity output inverted for one sense fails on half of the bytes, and an error flag with the wrong polarity fails on every receive case. The release cases check that a section that forgets to drop the parity enable, or leaves stale data on a released bus, is reported. The transmit cases check that a flag left armed by a bad parity input while transmitting is reported too.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;

   typedef enum logic [1:0] {
      XDIR_RX  = 2'b00,
      XDIR_TX  = 2'b01,
      XDIR_OFF = 2'b10
   } xdir_e;

   typedef enum int {
      PTREE_FLAT  = 0,
      PTREE_CHAIN = 1
   } ptree_e;

   function automatic xdir_e decode_dir(input logic tx, input logic hiz);
      if (hiz) return XDIR_OFF;
      return tx ? XDIR_TX : XDIR_RX;
   endfunction

endpackage

// File: rtl/parity_reduce.sv
module parity_reduce #(
   parameter int DW    = 8,
   parameter int STYLE = 0
) (
   input  logic [DW-1:0] data,
   output logic          odd_ones
);
   import parity_xcvr_pkg::*;

   if (DW < 1) begin : g_bad_dw
      $error("parity_reduce: DW must be at least 1");
   end
   if (STYLE != PTREE_FLAT && STYLE != PTREE_CHAIN) begin : g_bad_style
      $error("parity_reduce: unknown STYLE");
   end

   if (STYLE == PTREE_CHAIN) begin : g_chain
      logic [DW-1:0] link;
      assign link[0] = data[0];
      for (genvar i = 1; i < DW; i++) begin : g_step
         assign link[i] = link[i-1] ^ data[i];
      end
      assign odd_ones = link[DW-1];
   end else begin : g_flat
      assign odd_ones = ^data;
   end
endmodule

// File: rtl/parity_xcvr_lane.sv
module parity_xcvr_lane #(
   parameter int DW    = 8,
   parameter int STYLE = 0
) (
   input  logic          tx,
   input  logic          hiz,
   input  logic          odd,
   input  logic [DW-1:0] a_i,
   output logic [DW-1:0] a_o,
   output logic          a_e,
   input  logic [DW-1:0] b_i,
   output logic [DW-1:0] b_o,
   output logic          b_e,
   input  logic          p_i,
   output logic          p_o,
   output logic          p_e,
   output logic          e_n
);
   import parity_xcvr_pkg::*;

   xdir_e         mode;
   logic          a_odd;
   logic          b_odd;
   logic [DW-1:0] src;
   logic          src_odd;

   assign mode = decode_dir(tx, hiz);
   assign src  = (mode == XDIR_TX) ? a_i : b_i;

   parity_reduce #(.DW(DW), .STYLE(STYLE)) u_par (
      .data     (src),
      .odd_ones (src_odd)
   );

   assign a_odd = src_odd;
   assign b_odd = src_odd;

   always_comb begin
      a_o = '0;
      b_o = '0;
      a_e = 1'b0;
      b_e = 1'b0;
      p_o = 1'b0;
      p_e = 1'b0;
      e_n = 1'b1;
      unique case (mode)
         XDIR_TX: begin
            b_o = a_i;
            b_e = 1'b1;
            p_o = a_odd ^ odd;
            p_e = 1'b1;
         end
         XDIR_RX: begin
            a_o = b_i;
            a_e = 1'b1;
            e_n = ~(b_odd ^ p_i ^ odd);
         end
         default: begin
         end
      endcase
   end
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
   parameter int NSECT = 2,
   parameter int DW    = 8,
   parameter int STYLE = 0
) (
   input  logic [NSECT-1:0]    dir_tx,
   input  logic [NSECT-1:0]    hiz_req,
   input  logic [NSECT-1:0]    odd_sel,
   input  logic [NSECT*DW-1:0] a_in,
   output logic [NSECT*DW-1:0] a_out,
   output logic [NSECT-1:0]    a_drv,
   input  logic [NSECT*DW-1:0] b_in,
   output logic [NSECT*DW-1:0] b_out,
   output logic [NSECT-1:0]    b_drv,
   input  logic [NSECT-1:0]    par_in,
   output logic [NSECT-1:0]    par_out,
   output logic [NSECT-1:0]    par_drv,
   output logic [NSECT-1:0]    err_n
);
   localparam int BUSW = NSECT * DW;

   if (NSECT < 1) begin : g_bad_n
      $error("parity_xcvr: NSECT must be at least 1");
   end
   if (DW < 1 || BUSW > 4096) begin : g_bad_w
      $error("parity_xcvr: DW out of range");
   end

   for (genvar s = 0; s < NSECT; s++) begin : g_sect
      parity_xcvr_lane #(.DW(DW), .STYLE(STYLE)) u_lane (
         .tx  (dir_tx[s]),
         .hiz (hiz_req[s]),
         .odd (odd_sel[s]),
         .a_i (a_in[s*DW +: DW]),
         .a_o (a_out[s*DW +: DW]),
         .a_e (a_drv[s]),
         .b_i (b_in[s*DW +: DW]),
         .b_o (b_out[s*DW +: DW]),
         .b_e (b_drv[s]),
         .p_i (par_in[s]),
         .p_o (par_out[s]),
         .p_e (par_drv[s]),
         .e_n (err_n[s])
      );
   end
endmodule

// File: rtl/parity_xcvr_chk.sv
module parity_xcvr_chk #(
   parameter int NSECT = 2,
   parameter int DW    = 8
) (
   input logic [NSECT-1:0]    dir_tx,
   input logic [NSECT-1:0]    hiz_req,
   input logic [NSECT-1:0]    odd_sel,
   input logic [NSECT*DW-1:0] a_in,
   input logic [NSECT*DW-1:0] a_out,
   input logic [NSECT-1:0]    a_drv,
   input logic [NSECT*DW-1:0] b_in,
   input logic [NSECT*DW-1:0] b_out,
   input logic [NSECT-1:0]    b_drv,
   input logic [NSECT-1:0]    par_in,
   input logic [NSECT-1:0]    par_out,
   input logic [NSECT-1:0]    par_drv,
   input logic [NSECT-1:0]    err_n
);
   always_comb begin
      for (int s = 0; s < NSECT; s++) begin
         AST_SIDES_EXCLUSIVE: assert (!(a_drv[s] && b_drv[s])); // R9
         if (hiz_req[s]) begin
            AST_RELEASE_ALL: assert (!a_drv[s] && !b_drv[s] && !par_drv[s] && err_n[s]); // R3
         end
         if (!hiz_req[s] && dir_tx[s]) begin
            AST_TX_PATH: assert (b_drv[s] && b_out[s*DW +: DW] == a_in[s*DW +: DW]); // R1
            AST_TX_PARITY: assert (par_drv[s] && ($countones(a_in[s*DW +: DW]) + int'(par_out[s])) % 2 == int'(odd_sel[s])); // R4
            AST_TX_NO_FLAG: assert (err_n[s]); // R6
         end
         if (!hiz_req[s] && !dir_tx[s]) begin
            AST_RX_PATH: assert (a_drv[s] && a_out[s*DW +: DW] == b_in[s*DW +: DW]); // R2
            AST_RX_FLAG: assert (!par_drv[s] && (err_n[s] == (($countones(b_in[s*DW +: DW]) + int'(par_in[s])) % 2 == int'(odd_sel[s])))); // R5
         end
         if (!par_drv[s]) begin
            AST_IDLE_PARITY_ZERO: assert (par_out[s] == 1'b0); // R7
         end
      end
   end
endmodule

bind parity_xcvr parity_xcvr_chk #(.NSECT(NSECT), .DW(DW)) u_chk (
   .dir_tx  (dir_tx),
   .hiz_req (hiz_req),
   .odd_sel (odd_sel),
   .a_in    (a_in),
   .a_out   (a_out),
   .a_drv   (a_drv),
   .b_in    (b_in),
   .b_out   (b_out),
   .b_drv   (b_drv),
   .par_in  (par_in),
   .par_out (par_out),
   .par_drv (par_drv),
   .err_n   (err_n)
);

// File: tb/parity_xcvr_test.sv
`timescale 1ns/1ps
module parity_xcvr_test;
   localparam int NS = 2;
   localparam int W  = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [NS-1:0]   dir_tx, hiz_req, odd_sel, par_in;
   logic [NS*W-1:0] a_in, b_in;
   logic [NS*W-1:0] a_out, b_out;
   logic [NS-1:0]   a_drv, b_drv, par_out, par_drv, err_n;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   parity_xcvr #(.NSECT(NS), .DW(W)) uut (
      .dir_tx(dir_tx), .hiz_req(hiz_req), .odd_sel(odd_sel),
      .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
      .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
      .par_in(par_in), .par_out(par_out), .par_drv(par_drv), .err_n(err_n)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int ones(input logic [W-1:0] v);
      int n = 0;
      for (int i = 0; i < W; i++) n += int'(v[i]);
      return n;
   endfunction

   // Expected behaviour of one section, computed from the requirements.
   task automatic check_sec(input int s, input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic d, input logic h, input logic o, input logic p);
      logic [W-1:0] ea, eb;
      logic ead, ebd, ep, epd, ee;
      ea = '0; eb = '0; ead = 0; ebd = 0; ep = 0; epd = 0; ee = 1;
      if (!h && d) begin
         eb = a; ebd = 1; epd = 1;
         ep = ((ones(a) % 2) != int'(o)) ? 1'b1 : 1'b0;
      end else if (!h && !d) begin
         ea = b; ead = 1;
         ee = (((ones(b) + int'(p)) % 2) == int'(o)) ? 1'b1 : 1'b0;
      end
      chk(a_out[s*W +: W] == ea, h ? "R7 a_out released" : (d ? "R7 a_out in transmit" : "R2 a_out"), 32'(a_out[s*W +: W]), 32'(ea));
      chk(b_out[s*W +: W] == eb, h ? "R7 b_out released" : (d ? "R1 b_out" : "R7 b_out in receive"), 32'(b_out[s*W +: W]), 32'(eb));
      chk({a_drv[s], b_drv[s]} == {ead, ebd}, h ? "R3 data enables" : "R1 R2 R9 data enables", 32'({a_drv[s], b_drv[s]}), 32'({ead, ebd}));
      chk(par_drv[s] == epd, h ? "R3 parity enable" : (d ? "R4 parity enable" : "R5 parity enable"), 32'(par_drv[s]), 32'(epd));
      chk(par_out[s] == ep, d && !h ? "R4 parity value" : "R7 parity released", 32'(par_out[s]), 32'(ep));
      chk(err_n[s] == ee, h ? "R3 flag" : (d ? "R6 flag" : "R5 flag"), 32'(err_n[s]), 32'(ee));
   endtask

   initial begin
      // Reset-like state: every section released.
      dir_tx = '0; hiz_req = '1; odd_sel = '0; par_in = '0; a_in = '1; b_in = '1;
      @(negedge clk);
      #1;
      chk(a_drv == 0 && b_drv == 0 && par_drv == 0 && err_n == '1, "R3 initial release",
          32'({a_drv, b_drv, par_drv, err_n}), 32'(NS'('1)));

      // Spot cases: even with five ones drives 1; odd, parity 1, three ones flags.
      hiz_req = '0; dir_tx = 2'b01; odd_sel = 2'b10; par_in = 2'b10;
      a_in = {8'h00, 8'b0001_1111};
      b_in = {8'b0000_0111, 8'h00};
      @(negedge clk); #1;
      chk(par_out[0] == 1'b1, "R4 even five ones", 32'(par_out[0]), 32'd1);
      chk(err_n[1] == 1'b0, "R5 odd three ones", 32'(err_n[1]), 32'd0);

      // Exhaustive sweep of section 0; section 1 gets a shifted pattern (R8).
      for (int v = 0; v < 256; v++) begin
         for (int c = 0; c < 16; c++) begin
            logic [W-1:0] a0, b0, a1, b1;
            logic [NS-1:0] d, h, o, p;
            a0 = W'(v);
            b0 = W'(v * 7 + 3);
            a1 = ~a0;
            b1 = a0 ^ 8'h5A;
            d = {~c[0], c[0]};
            h = {c[1] & c[2], c[1]};
            o = {c[3], c[2]};
            p = {~c[3], c[3]};
            @(negedge clk);
            dir_tx = d; hiz_req = h; odd_sel = o; par_in = p;
            a_in = {a1, a0}; b_in = {b1, b0};
            #1;
            check_sec(0, a0, b0, d[0], h[0], o[0], p[0]);
            check_sec(1, a1, b1, d[1], h[1], o[1], p[1]);
         end
      end

      // R6: transmit flag stays high for every parity input and B pattern.
      hiz_req = '0; dir_tx = '1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         par_in = NS'(k); odd_sel = NS'(k >> 1); b_in = {NS{8'(k * 37)}};
         #1;
         chk(err_n == '1, "R6 transmit ignores checker inputs", 32'(err_n), 32'(NS'('1)));
      end
      done = 1'b1;
   end

   always @(posedge clk) begin
      cycles++;
      if (done || cycles > 100000) begin
         if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
         end
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule